// File: doc/BRIEF.md
# Soft-Decision Spreading-Code Correlator

This block despreads one baseband rail (I or Q) of a direct-sequence receiver. Each clock delivers one signed 3-bit converter sample, and two samples are taken per chip. The samples enter a tapped delay line with two taps per chip, 32 taps in all. Each tap is weighted by the sign of its reference chip, and the weighted taps are summed into a signed correlation score that is registered on every sample clock.

The reference chip pattern and the code length are loaded in one parallel write. The code length can be 11, 13, 15 or 16 chips. Taps beyond the selected length carry zero weight. After reset the reference is the 11-chip Barker code.

A small window tracker follows the score. It splits the sample stream into symbol windows of twice the code length and reports, once per window, the position in that window of the score with the largest magnitude. Later symbol-timing logic uses this position.

The tracker has three states:
- ST_OPEN takes the first sample of a window.
- ST_SCAN takes the middle samples.
- ST_CLOSE takes the last sample.

Its transitions are:
- ST_OPEN to ST_SCAN on every sample.
- ST_SCAN to ST_CLOSE when the index reaches 2L-2.
- ST_SCAN stays in ST_SCAN otherwise.
- ST_CLOSE to ST_OPEN on every sample.
- Any state to ST_OPEN on reset or on a reference load.

Top module: `barker_corr`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, the score and `peak_vld`. While zero samples follow reset, the score stays 0.
- R2: Samples are numbered from tap 0 (the newest) upward, and sample j belongs to chip c = j/2. For c < L, sample j is weighted +1 when bit (L-1-c) of the reference is 1 and -1 when that bit is 0. The score presented after an edge includes the sample captured at that edge.
- R3: After reset, the reference is 16'h00ED (bit i is chip i, 1 meaning +1) and L = 11. Eleven chips sent in order, each as two samples of amplitude +3, give a score of +66.
- R4: The score is 9 bits signed and covers the full range -128..+128 without wrapping.
- R5: `ref_len` selects the code length: 0 gives 11 chips, 1 gives 13, 2 gives 15 and 3 gives 16. Taps at or beyond 2L have zero weight.
- R6: With `ref_load` high, `ref_chips` and `ref_len` are captured at the edge. The score at that edge still uses the old reference, and the next score uses the new one. The delay line is not disturbed by a load.
- R7: Windows hold 2L samples, counted from the first sample after reset or after a load. `peak_vld` pulses for one cycle, together with the score of the window's last sample. At that time `peak_pos` gives the window index (0 to 2L-1) of the first sample with the largest score magnitude.
- R8: The sample taken at a load edge belongs to no window, and `peak_vld` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (two samples per chip) |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 3 | Signed converter sample |
| ref_load | input | 1 | Parallel load strobe for the reference |
| ref_chips | input | 16 | Reference chips, bit i is chip i, 1 means +1 |
| ref_len | input | 2 | Code length select |
| score | output | 9 | Signed correlation score |
| peak_vld | output | 1 | One-cycle pulse at the end of each window |
| peak_pos | output | 5 | Index of the largest-magnitude score in the window |

## Verification
Each sample applied before an edge appears in `score` right after that edge, so the bench checks the score between that edge and the next. A load changes the score one edge later than the edge that captures it, and the bench's model swaps its reference at the same point. `peak_vld` and `peak_pos` become valid after the edge that captures the last sample of a window, and the bench checks them in the same sampling slot as that sample's score. A load edge is checked for a missing pulse.

// File: rtl/barker_corr_pkg.sv
package barker_corr_pkg;

    typedef enum logic [1:0] {
        LEN_11 = 2'd0,
        LEN_13 = 2'd1,
        LEN_15 = 2'd2,
        LEN_16 = 2'd3
    } code_len_e;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_SCAN,
        ST_CLOSE
    } win_state_e;

    localparam logic [15:0] BARKER11 = 16'h00ED;

    function automatic logic [4:0] chips_of(input code_len_e sel);
        logic [4:0] n;
        unique case (sel)
            LEN_11:  n = 5'd11;
            LEN_13:  n = 5'd13;
            LEN_15:  n = 5'd15;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bc_delay_line.sv
module bc_delay_line #(
    parameter int SW   = 3,
    parameter int TAPS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SW-1:0]      din,
    output logic [TAPS*SW-1:0] taps_q
);
    logic [TAPS-1:0][SW-1:0] q;

    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= '0;
                else if (i == 0)
                    q[i] <= din;
                else
                    q[i] <= q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign taps_q = q;

    // R2: every tap takes its neighbour's previous value
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q[1] == $past(q[0])));

endmodule

// File: rtl/bc_weight_sum.sv
module bc_weight_sum #(
    parameter int SW        = 3,
    parameter int MAX_CHIPS = 16,
    parameter int SPC       = 2,
    parameter int OUT_W     = 9,
    parameter int CW        = 5
) (
    input  logic [SPC*MAX_CHIPS*SW-1:0] taps,
    input  logic [MAX_CHIPS-1:0]        ref_chips,
    input  logic [CW-1:0]               n_chips,
    output logic signed [OUT_W-1:0]     sum
);
    localparam int TAPS = SPC * MAX_CHIPS;
    localparam int RW   = $clog2(MAX_CHIPS);

    always_comb begin
        logic signed [OUT_W-1:0] acc;
        logic signed [OUT_W-1:0] smp;
        logic [RW-1:0]           ri;
        acc = '0;
        for (int j = 0; j < TAPS; j++) begin
            smp = OUT_W'($signed(taps[j*SW +: SW]));
            ri  = RW'(int'(n_chips) - 1 - (j / SPC));
            if ((j / SPC) < int'(n_chips)) begin
                if (ref_chips[ri])
                    acc = acc + smp;
                else
                    acc = acc - smp;
            end
        end
        sum = acc;
    end

endmodule

// File: rtl/bc_peak_track.sv
module bc_peak_track
    import barker_corr_pkg::*;
#(
    parameter int SCORE_W = 9,
    parameter int PW      = 5,
    parameter int CW      = 5,
    parameter int SPC     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic signed [SCORE_W-1:0] score_nxt,
    input  logic [CW-1:0]             n_chips,
    output logic                      peak_vld,
    output logic [PW-1:0]             peak_pos
);
    win_state_e         state_q, state_d;
    logic [PW-1:0]      cnt_q, pos_q, sel_pos;
    logic [SCORE_W-1:0] best_q, sel_best, mag;
    logic [PW:0]        win_len;
    logic               take;

    assign win_len  = (PW+1)'(n_chips) * (PW+1)'(SPC);
    assign mag      = score_nxt[SCORE_W-1] ? SCORE_W'(-score_nxt) : SCORE_W'(score_nxt);
    assign take     = (state_q == ST_OPEN) || (mag > best_q);
    assign sel_pos  = take ? cnt_q : pos_q;
    assign sel_best = take ? mag : best_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:  state_d = ST_SCAN;
            ST_SCAN:  state_d = ((PW+1)'(cnt_q) == win_len - 2) ? ST_CLOSE : ST_SCAN;
            ST_CLOSE: state_d = ST_OPEN;
            default:  state_d = ST_OPEN;
        endcase
        if (restart)
            state_d = ST_OPEN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_OPEN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q    <= '0;
            pos_q    <= '0;
            best_q   <= '0;
            peak_vld <= 1'b0;
            if (rst)
                peak_pos <= '0;
        end else begin
            cnt_q    <= (state_q == ST_CLOSE) ? '0 : cnt_q + 1'b1;
            pos_q    <= sel_pos;
            best_q   <= sel_best;
            peak_vld <= (state_q == ST_CLOSE);
            if (state_q == ST_CLOSE)
                peak_pos <= sel_pos;
        end
    end

    // R7: a closing sample always yields a flag
    p_close_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLOSE && !restart) |=> peak_vld);
    // R7: the flag is a single-cycle pulse
    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        peak_vld |=> !peak_vld);
    // R7: reported position lies inside the window
    p_pos_range_r7: assert property (@(posedge clk) disable iff (rst)
        peak_vld |-> ((PW+1)'(peak_pos) < win_len));
    // R8: a load reopens the window without a flag
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!peak_vld && state_q == ST_OPEN));

endmodule

// File: rtl/barker_corr.sv
module barker_corr
    import barker_corr_pkg::*;
#(
    parameter int SW        = 3,
    parameter int MAX_CHIPS = 16,
    parameter int SPC       = 2,
    parameter int SCORE_W   = SW + $clog2(SPC*MAX_CHIPS) + 1,
    parameter int PW        = $clog2(SPC*MAX_CHIPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SW-1:0]        smp_in,
    input  logic                 ref_load,
    input  logic [MAX_CHIPS-1:0] ref_chips,
    input  logic [1:0]           ref_len,
    output logic [SCORE_W-1:0]   score,
    output logic                 peak_vld,
    output logic [PW-1:0]        peak_pos
);
    localparam int TAPS = SPC * MAX_CHIPS;
    localparam int CW   = $clog2(MAX_CHIPS + 1);
    localparam int BOUND = TAPS * (2 ** (SW - 1));

    logic [TAPS*SW-1:0]        line_q, line_nxt;
    logic [MAX_CHIPS-1:0]      ref_q;
    code_len_e                 len_q;
    logic [CW-1:0]             n_chips;
    logic signed [SCORE_W-1:0] sum_nxt, score_q;

    assign n_chips  = CW'(chips_of(len_q));
    assign line_nxt = {line_q[(TAPS-1)*SW-1:0], smp_in};

    bc_delay_line #(.SW(SW), .TAPS(TAPS)) u_line (
        .clk    (clk),
        .rst    (rst),
        .din    (smp_in),
        .taps_q (line_q)
    );

    bc_weight_sum #(.SW(SW), .MAX_CHIPS(MAX_CHIPS), .SPC(SPC),
                    .OUT_W(SCORE_W), .CW(CW)) u_sum (
        .taps      (line_nxt),
        .ref_chips (ref_q),
        .n_chips   (n_chips),
        .sum       (sum_nxt)
    );

    bc_peak_track #(.SCORE_W(SCORE_W), .PW(PW), .CW(CW), .SPC(SPC)) u_peak (
        .clk       (clk),
        .rst       (rst),
        .restart   (ref_load),
        .score_nxt (sum_nxt),
        .n_chips   (n_chips),
        .peak_vld  (peak_vld),
        .peak_pos  (peak_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= MAX_CHIPS'(BARKER11);
            len_q   <= LEN_11;
            score_q <= '0;
        end else begin
            score_q <= sum_nxt;
            if (ref_load) begin
                ref_q <= ref_chips;
                len_q <= code_len_e'(ref_len);
            end
        end
    end

    assign score = score_q;

    // R3: reset restores the default code
    p_default_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ref_q == MAX_CHIPS'(BARKER11) && len_q == LEN_11));
    // R6: the reference only changes on a load
    p_ref_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(ref_load) |-> ($stable(ref_q) && $stable(len_q)));
    // R4: the score never leaves the representable bound
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        ($signed(score_q) <= BOUND) && ($signed(score_q) >= -BOUND));

endmodule

// File: tb/barker_corr_tb.sv
module barker_corr_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  smp_in;
    logic        ref_load;
    logic [15:0] ref_chips;
    logic [1:0]  ref_len;
    logic [8:0]  score;
    logic        peak_vld;
    logic [4:0]  peak_pos;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int          hist [32];
    logic [15:0] mref;
    int          mlen, cnt, best, bpos;

    always #2.5 clk = ~clk;

    barker_corr u_dut (
        .clk(clk), .rst(rst), .smp_in(smp_in), .ref_load(ref_load),
        .ref_chips(ref_chips), .ref_len(ref_len),
        .score(score), .peak_vld(peak_vld), .peak_pos(peak_pos)
    );

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'd0: return 11;
            2'd1: return 13;
            2'd2: return 15;
            default: return 16;
        endcase
    endfunction

    function automatic int corr();
        int acc = 0;
        for (int j = 0; j < 32; j++) begin
            if (j / 2 < mlen)
                acc += mref[mlen - 1 - j / 2] ? hist[j] : -hist[j];
        end
        return acc;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int s, input bit ld, input logic [15:0] rc,
                        input logic [1:0] rl, input bit r, input string tag);
        int es, ev, ep, mag;
        @(negedge clk);
        rst = r; smp_in = 3'(s); ref_load = ld; ref_chips = rc; ref_len = rl;
        ev = 0; ep = 0;
        if (r) begin
            for (int j = 0; j < 32; j++) hist[j] = 0;
            mref = 16'h00ED; mlen = 11; cnt = 0; best = 0; bpos = 0; es = 0;
        end else begin
            for (int j = 31; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = s;
            es = corr();
            if (ld) begin
                cnt = 0;
                mref = rc; mlen = len_of(rl);
            end else begin
                mag = (es < 0) ? -es : es;
                if (cnt == 0 || mag > best) begin best = mag; bpos = cnt; end
                if (cnt == 2 * mlen - 1) begin
                    ev = 1; ep = bpos; cnt = 0;
                end else cnt++;
            end
        end
        @(posedge clk);
        #2;
        chk({tag, " score"}, int'($signed(score)), es);
        chk({tag, " peak_vld"}, int'(peak_vld), ev);
        if (ev) chk({tag, " peak_pos"}, int'(peak_pos), ep);
    endtask

    task automatic t_reset();
        step(3, 0, 16'h0, 2'd0, 1, "R1 reset");
        step(-2, 0, 16'h0, 2'd0, 1, "R1 reset");
        for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 2'd0, 0, "R1 cleared line");
    endtask

    task automatic t_barker();
        logic [15:0] b = 16'h00ED;
        step(0, 1, 16'h0, 2'd0, 1, "R3 reset");
        for (int c = 0; c < 11; c++) begin
            step(b[c] ? 3 : -3, 0, 16'h0, 2'd0, 0, "R3 barker");
            step(b[c] ? 3 : -3, 0, 16'h0, 2'd0, 0, "R3 barker");
        end
        chk("R3 aligned peak", int'($signed(score)), 66);
        chk("R7 peak at last index", int'(peak_pos), 21);
        for (int i = 0; i < 30; i++) step((i % 7) - 3, 0, 16'h0, 2'd0, 0, "R2 mixed");
    endtask

    task automatic t_extremes();
        step(-4, 1, 16'hFFFF, 2'd3, 0, "R6 load");
        for (int i = 0; i < 31; i++) step(-4, 0, 16'h0, 2'd0, 0, "R4 min");
        chk("R4 min -128", int'($signed(score)), -128);
        step(-4, 1, 16'h0000, 2'd3, 0, "R6 load keeps line");
        step(-4, 0, 16'h0, 2'd0, 0, "R4 max");
        chk("R4 max +128", int'($signed(score)), 128);
    endtask

    task automatic t_lengths();
        for (int sel = 0; sel < 4; sel++) begin
            step(1, 1, 16'hA5C3 ^ 16'(sel * 16'h1111), 2'(sel), 0, "R5 load");
            for (int i = 0; i < 40; i++)
                step(((i * 5 + sel) % 8) - 4, 0, 16'h0, 2'd0, 0, "R5 length");
        end
    endtask

    task automatic t_peak();
        step(0, 1, 16'h00ED, 2'd0, 0, "R7 load");
        for (int i = 0; i < 40; i++) step(0, 0, 16'h0, 2'd0, 0, "R7 zero tie");
        for (int i = 0; i < 50; i++)
            step(((i * 3) % 8) - 4, 0, 16'h0, 2'd0, 0, "R7 peak");
    endtask

    task automatic t_load_mid();
        for (int i = 0; i < 7; i++) step(2, 0, 16'h0, 2'd0, 0, "R8 pre");
        step(-3, 1, 16'h1234, 2'd1, 0, "R8 load edge");
        for (int i = 0; i < 30; i++) step((i % 5) - 2, 0, 16'h0, 2'd0, 0, "R8 new window");
        step(1, 1, 16'h4321, 2'd2, 0, "R8 load edge");
        for (int i = 0; i < 32; i++) step(3 - (i % 8), 0, 16'h0, 2'd0, 0, "R8 new window");
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; smp_in = 0; ref_load = 0; ref_chips = 0; ref_len = 0;
        t_reset();
        t_barker();
        t_extremes();
        t_lengths();
        t_peak();
        t_load_mid();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule